// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller

This block sits between a set of peripheral interrupt wires and a processor core. It watches 32 level-sensitive request inputs. The low inputs feed a raw pending register. Each raw pending bit tracks the level of its input with no latching. A mask register written by software selects which pending bits may interrupt the core. The controller then drives a maskable request line and an 8-bit vector bus. When exactly one unmasked request is active, the vector names that request. When several are active, the vector is a single shared value, and software must scan the masked pending register to choose what to service first.

The two highest inputs bypass the mask. They drive a non-maskable status register and a separate non-maskable interrupt line. All state can be read over a simple 32-bit word-addressed register bus. A read is combinational and takes effect in the same cycle as the select. A write takes effect at the next clock edge. All three core-facing outputs are registered, and they reflect an input change or a mask write one clock after it happens.

Top module: `intc_lvl_vec`

## Requirements
- R1: After synchronous reset, every readable register is zero, and `irq_req_o`, `irq_vec_o` and `nmi_o` are low.
- R2: For n from 1 to 29, bit n-1 of the raw pending register (offset 1) equals the level of `irq_in[n]` sampled at the previous clock edge. Raw bits 29 to 31 always read zero.
- R3: `irq_in[0]` is ignored. It sets no pending bit, no status bit and no output.
- R4: The masked pending register (offset 2) always equals the raw pending register ANDed bitwise with the mask register (offset 0).
- R5: When exactly one masked pending bit is set, at bit position i, `irq_vec_o` is 0x31 + i.
- R6: When two or more masked pending bits are set, `irq_vec_o` is 0x30, whichever bits they are.
- R7: When no masked pending bit is set, `irq_vec_o` is 0 and `irq_req_o` is low. `irq_req_o` is high exactly when `irq_vec_o` is nonzero.
- R8: `irq_in[30]` and `irq_in[31]` never enter the raw pending register. Each one sets or clears the bit of the same index in the NMI status register (offset 3), following its level with one clock of latency.
- R9: `nmi_o` is the OR of the NMI status bits, and the mask register has no effect on it.
- R10: Only offset 0 is writable, and writes to offsets 1 to 7 change no register. A mask write updates `irq_vec_o` and `irq_req_o` at the same clock edge that loads the mask.
- R11: Offset 4 and offsets 5 to 7 read as zero. A read changes no pending or status state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive request inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| irq_req_o | output | 1 | Maskable interrupt request to the core |
| irq_vec_o | output | 8 | Interrupt vector to the core |
| nmi_o | output | 1 | Non-maskable interrupt to the core |

## Verification
Each pending input is first raised alone with every bit unmasked. This tells the one-hot vector formula apart from any off-by-one error in how inputs map to pending bits. All pairs of pending inputs are then swept, which separates the shared vector from a priority encoder that would pick the lowest or highest bit. Next, all inputs are held high while the mask is swept one bit at a time. This exercises the AND of the masked view, the effect of a mask write on the outputs in the same cycle, and the mask bits that have no pending source behind them. Finally, the bench toggles the non-maskable inputs and input 0 under full and empty masks, and writes to read-only offsets. These steps show that those paths stay apart from the vector logic and that the read-only registers are unaffected.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned OFS_W  = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_MASK   = 3'd0,
        OFS_RAW    = 3'd1,
        OFS_MASKED = 3'd2,
        OFS_NMI    = 3'd3,
        OFS_DIAG   = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
    } core_irq_t;

    // Classify a masked pending word: none, one (named by its index), many (shared).
    function automatic core_irq_t encode_vec(
        input logic [WORD_W-1:0] masked,
        input logic [VEC_W-1:0]  shared_v,
        input logic [VEC_W-1:0]  base_v
    );
        core_irq_t    r;
        int unsigned  cnt;
        logic [VEC_W-1:0] idx;
        cnt = 0;
        idx = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (masked[k]) begin
                cnt = cnt + 1;
                idx = VEC_W'(k);
            end
        end
        if (cnt == 0) begin
            r.req = 1'b0;
            r.vec = '0;
        end else if (cnt == 1) begin
            r.req = 1'b1;
            r.vec = base_v + idx;
        end else begin
            r.req = 1'b1;
            r.vec = shared_v;
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_req_capture.sv
module intc_req_capture
    import intc_pkg::*;
#(
    parameter int unsigned NUM_IN    = 32,
    parameter int unsigned NMI_FIRST = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    output logic [WORD_W-1:0] raw_d,
    output logic [WORD_W-1:0] raw_q,
    output logic [WORD_W-1:0] nmi_d,
    output logic [WORD_W-1:0] nmi_q
);

    // Raw bit b follows input b+1; input 0 and the NMI inputs have no raw bit.
    for (genvar b = 0; b < WORD_W; b++) begin : g_raw
        if ((b + 1 < NMI_FIRST) && (b + 1 < NUM_IN)) begin : g_live
            assign raw_d[b] = irq_in[b+1];
        end else begin : g_zero
            assign raw_d[b] = 1'b0;
        end
    end

    // NMI status bit b follows input b for the top inputs only.
    for (genvar b = 0; b < WORD_W; b++) begin : g_nmi
        if ((b >= NMI_FIRST) && (b < NUM_IN)) begin : g_live
            assign nmi_d[b] = irq_in[b];
        end else begin : g_zero
            assign nmi_d[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            nmi_q <= '0;
        end else begin
            raw_q <= raw_d;
            nmi_q <= nmi_d;
        end
    end

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] raw_q,
    input  logic [WORD_W-1:0] nmi_q,
    output logic [WORD_W-1:0] mask_d,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] bus_rdata
);

    logic mask_we;

    assign mask_we = bus_sel && bus_wr && (reg_ofs_e'(bus_ofs) == OFS_MASK);

    always_comb begin
        mask_d = mask_q;
        if (mask_we) begin
            mask_d = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (reg_ofs_e'(bus_ofs))
                OFS_MASK:   bus_rdata = mask_q;
                OFS_RAW:    bus_rdata = raw_q;
                OFS_MASKED: bus_rdata = raw_q & mask_q;
                OFS_NMI:    bus_rdata = nmi_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/intc_vec_encoder.sv
module intc_vec_encoder
    import intc_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_SHARED = 8'h30,
    parameter logic [VEC_W-1:0] VEC_BASE   = 8'h31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] masked_d,
    input  logic [WORD_W-1:0] nmi_d,
    output logic              irq_req_q,
    output logic [VEC_W-1:0]  irq_vec_q,
    output logic              nmi_any_q
);

    core_irq_t enc_d;
    core_irq_t enc_q;

    always_comb begin
        enc_d = encode_vec(masked_d, VEC_SHARED, VEC_BASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_q     <= '0;
            nmi_any_q <= 1'b0;
        end else begin
            enc_q     <= enc_d;
            nmi_any_q <= |nmi_d;
        end
    end

    assign irq_req_q = enc_q.req;
    assign irq_vec_q = enc_q.vec;

endmodule

// File: rtl/intc_lvl_vec.sv
module intc_lvl_vec
    import intc_pkg::*;
#(
    parameter int unsigned      NUM_IN     = 32,
    parameter int unsigned      NMI_FIRST  = 30,
    parameter logic [VEC_W-1:0] VEC_SHARED = 8'h30,
    parameter logic [VEC_W-1:0] VEC_BASE   = 8'h31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic              nmi_o
);

    logic [WORD_W-1:0] raw_d, raw_q;
    logic [WORD_W-1:0] nmi_d, nmi_q;
    logic [WORD_W-1:0] mask_d, mask_q;
    logic [WORD_W-1:0] masked_d;

    intc_req_capture #(
        .NUM_IN    (NUM_IN),
        .NMI_FIRST (NMI_FIRST)
    ) u_capture (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .raw_d  (raw_d),
        .raw_q  (raw_q),
        .nmi_d  (nmi_d),
        .nmi_q  (nmi_q)
    );

    intc_regbank u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_ofs   (bus_ofs),
        .bus_wdata (bus_wdata),
        .raw_q     (raw_q),
        .nmi_q     (nmi_q),
        .mask_d    (mask_d),
        .mask_q    (mask_q),
        .bus_rdata (bus_rdata)
    );

    // Next-state view so outputs land in the same cycle as the registers.
    assign masked_d = raw_d & mask_d;

    intc_vec_encoder #(
        .VEC_SHARED (VEC_SHARED),
        .VEC_BASE   (VEC_BASE)
    ) u_enc (
        .clk       (clk),
        .rst       (rst),
        .masked_d  (masked_d),
        .nmi_d     (nmi_d),
        .irq_req_q (irq_req_o),
        .irq_vec_q (irq_vec_o),
        .nmi_any_q (nmi_o)
    );

endmodule

// File: rtl/intc_lvl_vec_chk.sv
module intc_lvl_vec_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [31:0]       irq_in,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [OFS_W-1:0]  bus_ofs,
    input logic [WORD_W-1:0] raw_q,
    input logic [WORD_W-1:0] mask_q,
    input logic [WORD_W-1:0] nmi_q,
    input logic              irq_req_o,
    input logic [VEC_W-1:0]  irq_vec_o,
    input logic              nmi_o
);

    logic [WORD_W-1:0] masked_now;
    assign masked_now = raw_q & mask_q;

    AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw_q[28:0] == $past(irq_in[29:1]))); // R2

    AST_RAW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        raw_q[31:29] == 3'b000); // R8

    AST_VEC_ONE: assert property (@(posedge clk) disable iff (rst)
        ($countones(masked_now) == 1) |->
            ((irq_vec_o >= 8'h31) && (masked_now == (32'h1 << (irq_vec_o - 8'h31))))); // R5

    AST_VEC_MANY: assert property (@(posedge clk) disable iff (rst)
        ($countones(masked_now) > 1) |-> (irq_vec_o == 8'h30)); // R6

    AST_VEC_NONE: assert property (@(posedge clk) disable iff (rst)
        (masked_now == '0) |-> (irq_vec_o == '0 && !irq_req_o)); // R7

    AST_REQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_req_o == (irq_vec_o != '0)); // R7

    AST_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (nmi_q[31:30] == $past(irq_in[31:30]) && nmi_q[29:0] == '0)); // R8

    AST_NMI_OR: assert property (@(posedge clk) disable iff (rst)
        nmi_o == (nmi_q != '0)); // R9

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_ofs == 3'd0) |=> $stable(mask_q)); // R10

endmodule

bind intc_lvl_vec intc_lvl_vec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_ofs   (bus_ofs),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .nmi_q     (nmi_q),
    .irq_req_o (irq_req_o),
    .irq_vec_o (irq_vec_o),
    .nmi_o     (nmi_o)
);

// File: tb/intc_lvl_vec_bench.sv
`timescale 1ns/1ps
module intc_lvl_vec_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_ofs = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req_o;
    logic [7:0]  irq_vec_o;
    logic        nmi_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    intc_lvl_vec u_intc_lvl_vec (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_ofs   (bus_ofs),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req_o (irq_req_o),
        .irq_vec_o (irq_vec_o),
        .nmi_o     (nmi_o)
    );

    function automatic logic [7:0] exp_vec(input logic [31:0] m);
        int c;
        c = $countones(m);
        if (c == 0) return 8'h00;
        if (c == 1) return 8'h31 + 8'($clog2(m));
        return 8'h30;
    endfunction

    function automatic logic [31:0] exp_raw(input logic [31:0] lv);
        return (lv >> 1) & 32'h1FFF_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] ofs, output logic [31:0] d);
        bus_sel = 1'b1;
        bus_wr  = 1'b0;
        bus_ofs = ofs;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Write at a negedge; the next negedge sees the result.
    task automatic wr(input logic [2:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1;
        bus_wr  = 1'b1;
        bus_ofs = ofs;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic drive(input logic [31:0] lv);
        @(negedge clk);
        irq_in = lv;
        @(negedge clk);
    endtask

    task automatic check_outs(input string tag, input logic [31:0] lv, input logic [31:0] mask);
        logic [7:0] ev;
        ev = exp_vec(exp_raw(lv) & mask);
        chk({tag, " vec"}, {24'h0, irq_vec_o}, {24'h0, ev});
        chk({tag, " req"}, {31'h0, irq_req_o}, {31'h0, ev != 8'h00});
        chk({tag, " nmi"}, {31'h0, nmi_o}, {31'h0, lv[31] | lv[30]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] lv;
        logic [31:0] mk;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int o = 0; o < 8; o++) begin
            rd(3'(o), d);
            chk("R1 reg", d, 32'h0);
        end
        check_outs("R1", 32'h0, 32'h0);

        // R5 / R2: one input at a time, full mask
        wr(3'd0, 32'hFFFF_FFFF);
        for (int n = 1; n < 30; n++) begin
            lv = 32'h1 << n;
            drive(lv);
            check_outs("R5 single", lv, 32'hFFFF_FFFF);
            chk("R5 vec formula", {24'h0, irq_vec_o}, 32'h31 + 32'(n - 1));
            rd(3'd1, d);
            chk("R2 raw", d, 32'h1 << (n - 1));
        end

        // R3: input 0 ignored
        drive(32'h1);
        check_outs("R3", 32'h1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        chk("R3 raw", d, 32'h0);
        rd(3'd3, d);
        chk("R3 nmi", d, 32'h0);

        // R6: every pair of pending inputs
        for (int i = 1; i < 30; i++) begin
            for (int j = i + 1; j < 30; j++) begin
                lv = (32'h1 << i) | (32'h1 << j);
                drive(lv);
                chk("R6 pair vec", {24'h0, irq_vec_o}, 32'h30);
                chk("R6 pair req", {31'h0, irq_req_o}, 32'h1);
            end
        end

        // R7: nothing pending
        drive(32'h0);
        check_outs("R7 idle", 32'h0, 32'hFFFF_FFFF);

        // R4 / R10: all inputs high, sweep single mask bits
        lv = 32'hFFFF_FFFE;
        drive(lv);
        rd(3'd2, d);
        chk("R4 full", d, 32'h1FFF_FFFF);
        for (int b = 0; b < 32; b++) begin
            mk = 32'h1 << b;
            wr(3'd0, mk);
            check_outs("R10 mask write", lv, mk);
            rd(3'd2, d);
            chk("R4 masked", d, mk & 32'h1FFF_FFFF);
            rd(3'd0, d);
            chk("R10 mask read", d, mk);
        end
        wr(3'd0, 32'h0000_0000);
        check_outs("R7 masked off", lv, 32'h0);

        // R8 / R9: NMI inputs, mask zero
        drive(32'h4000_0000);
        chk("R9 nmi30", {31'h0, nmi_o}, 32'h1);
        rd(3'd3, d);
        chk("R8 nmi status", d, 32'h4000_0000);
        rd(3'd1, d);
        chk("R8 raw clean", d, 32'h0);
        drive(32'h8000_0000);
        rd(3'd3, d);
        chk("R8 nmi31", d, 32'h8000_0000);
        chk("R9 nmi31 out", {31'h0, nmi_o}, 32'h1);
        drive(32'h0);
        chk("R8 nmi clear", {31'h0, nmi_o}, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        drive(32'hC000_0000);
        check_outs("R8 nmi full mask", 32'hC000_0000, 32'hFFFF_FFFF);

        // R10 / R11: writes elsewhere ignored, read offsets 4..7 zero
        drive(32'h0000_0006);
        for (int o = 1; o < 8; o++) begin
            wr(3'(o), 32'h0);
            rd(3'd0, d);
            chk("R10 mask unchanged", d, 32'hFFFF_FFFF);
            check_outs("R10 outputs unchanged", 32'h0000_0006, 32'hFFFF_FFFF);
        end
        for (int o = 4; o < 8; o++) begin
            rd(3'(o), d);
            chk("R11 zero read", d, 32'h0);
        end
        rd(3'd1, d);
        chk("R11 raw after reads", d, 32'h3);
        rd(3'd2, d);
        chk("R11 masked after reads", d, 32'h3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule